// File: doc/BRIEF.md
# Set/LRU Approximate Timestamp Memory

This block is a small set-associative store for conflict timestamps. It sits beside a core's cache but has its own tags and does not touch the cache arrays. For each line address the core has touched recently, it keeps the low bits of the instruction count (IC) from the core's last access. A record port writes the current IC whenever the core issues a load or a store. A lookup port is driven by incoming coherence requests. It returns a full-width timestamp one cycle later, and that timestamp travels on the coherence response.

A lookup can miss because the line was evicted from the store or never entered it. In that case the block does not signal failure. It returns a conservative value. By default this is the stamp held in the least recently used way of the indexed set. Recency order guarantees that this stamp is no older than any entry evicted from that set. A mode input can select the core's current IC instead, which is also safe but more pessimistic.

Stamps are stored in partial form. The full value is rebuilt from the upper bits of the current IC. A parameter chooses between a single stamp per entry and a split form. In the split form, stores keep a separate stamp, so that shared requests only see the last local store.

Top module: `tsm_stamp_store`

## Requirements
- R1: After reset, rsp_valid and rsp_hit are 0 and rsp_ts is 0. Every way of every set is empty.
- R2: A lookup accepted with lk_valid=1 yields rsp_valid=1 exactly one cycle later. rsp_valid is 0 in the cycle after lk_valid=0. rsp_hit and rsp_ts are 0 whenever rsp_valid is 0. A lookup never alters the stored contents.
- R3: The set index is the low log2(SETS) bits of the line address, and the tag is the remaining upper bits. A lookup of an address recorded in an earlier cycle, with no eviction in between, hits and returns the stamp of its latest access.
- R4: A record to an address already present refreshes its stamp and makes that way most recent. A record to an absent address fills an empty way if the set has one. Otherwise it replaces the least recently recorded entry.
- R5: With miss_mode=0, a missing lookup returns the rebuilt stamp of the set's least recently used entry. If the set still has an empty way, the stored part used is zero.
- R6: With miss_mode=1, a missing lookup returns cur_ic of the request cycle unchanged.
- R7: A stored part P is rebuilt at IC value C as {C[IC_W-1:TS_W], P}. If that value exceeds C, 2^TS_W is subtracted, modulo 2^IC_W.
- R8: With SPLIT_RW=1, lk_excl=1 returns the latest access of either kind and lk_excl=0 returns the latest store. A load that inserts a new entry sets both stamps. With SPLIT_RW=0, both lookup kinds return the latest access.
- R9: When a record and a lookup occur in the same cycle, the lookup sees the contents as they were before that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_ic | input | IC_W | Current instruction count of the core |
| rec_valid | input | 1 | Core access to record this cycle |
| rec_addr | input | ADDR_W | Line address of the core access |
| rec_store | input | 1 | 1 for a store, 0 for a load |
| lk_valid | input | 1 | Coherence lookup request this cycle |
| lk_addr | input | ADDR_W | Line address of the lookup |
| lk_excl | input | 1 | 1 for an exclusive (write) request, 0 for a shared one |
| miss_mode | input | 1 | Miss answer: 0 gives the set's LRU stamp, 1 gives the current IC |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup address was present |
| rsp_ts | output | IC_W | Full-width timestamp for the response |

## Verification
Two configurations, one with split and one with unified stamps, are driven with identical stimulus. They are compared against an arithmetic model that tracks recency with a global sequence number rather than age counters.

Directed sequences fill one set and then overflow it. A refresh is placed before an eviction to separate true LRU order from insertion order. A store followed by a load separates the shared answer from the exclusive answer. A same-cycle record and lookup exposes the read-before-write ordering. An old stamp read after the IC crosses a 2^TS_W boundary exercises the borrow.

A long pseudo-random mix of records and lookups then runs over a 64-line address space, with both miss modes and a steadily wrapping IC. It ends with a lookup sweep of every address, in both kinds, which exposes hidden state corruption.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    // Answer given for a lookup whose line is not held in the store.
    typedef enum logic {
        MISS_LRU_STAMP  = 1'b0,
        MISS_CURRENT_IC = 1'b1
    } miss_policy_e;

    // Index width for a count of n items, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tsm_tag_match.sv
module tsm_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 4,
    localparam int WAY_W = tsm_pkg::idx_bits(WAYS)
) (
    input  logic [WAYS-1:0]       row_vld,
    input  logic [WAYS*TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]      key,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);

    logic [WAYS-1:0] eq;

    // One comparator per way, all in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = row_vld[w] && (row_tag[w*TAG_W +: TAG_W] == key);
    end

    // Encode the matching way; a legal set holds each tag at most once.
    always_comb begin
        hit     = |eq;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/tsm_lru_victim.sv
module tsm_lru_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = tsm_pkg::idx_bits(WAYS)
) (
    input  logic [WAYS-1:0]       row_vld,
    input  logic [WAYS*WAY_W-1:0] row_age,
    output logic [WAY_W-1:0]      victim
);

    logic [WAYS-1:0] empty_vec;
    logic [WAYS-1:0] oldest_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_flag
        assign empty_vec[w]  = !row_vld[w];
        assign oldest_vec[w] = (row_age[w*WAY_W +: WAY_W] == WAY_W'(WAYS - 1));
    end

    // Lowest-numbered empty way first; otherwise the way whose age is maximal.
    always_comb begin
        victim = '0;
        if (|empty_vec) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (empty_vec[w]) begin
                    victim = WAY_W'(w);
                end
            end
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (oldest_vec[w]) begin
                    victim = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/tsm_ts_rebuild.sv
module tsm_ts_rebuild #(
    parameter int IC_W = 12,
    parameter int TS_W = 8
) (
    input  logic [IC_W-1:0] ic,
    input  logic [TS_W-1:0] part,
    output logic [IC_W-1:0] full
);

    if (IC_W > TS_W) begin : g_join
        logic [IC_W-1:0] cand;

        always_comb begin
            cand = {ic[IC_W-1:TS_W], part};
            // A stamp from the past cannot lie ahead of the present count:
            // borrow one from the upper bits in that case.
            if (cand > ic) begin
                full = cand - (IC_W'(1) << TS_W);
            end else begin
                full = cand;
            end
        end

        always_comb begin
            if (ic[IC_W-1:TS_W] != '0) begin
                AST_NOT_AHEAD: assert (full <= ic); // R7
            end
        end
    end else begin : g_full
        assign full = IC_W'(part);
    end

endmodule

// File: rtl/tsm_stamp_store.sv
module tsm_stamp_store #(
    parameter int SETS     = 32,
    parameter int WAYS     = 64,
    parameter int ADDR_W   = 26,
    parameter int IC_W     = 40,
    parameter int TS_W     = 24,
    parameter bit SPLIT_RW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IC_W-1:0]   cur_ic,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic              rec_store,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_excl,
    input  logic              miss_mode,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IC_W-1:0]   rsp_ts
);

    import tsm_pkg::*;

    localparam int IDX_W = idx_bits(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int WAY_W = idx_bits(WAYS);

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic [IC_W-1:0] ts;
    } rsp_t;

    // ---------------------------------------------------------------
    // Storage: valid, tag, age rank, stamp of any access, stamp of stores
    // ---------------------------------------------------------------
    logic             vld_q [SETS][WAYS];
    logic             vld_d [SETS][WAYS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_d [SETS][WAYS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] age_d [SETS][WAYS];
    logic [TS_W-1:0]  tsa_q [SETS][WAYS];
    logic [TS_W-1:0]  tsa_d [SETS][WAYS];
    logic [TS_W-1:0]  tsw_q [SETS][WAYS];
    logic [TS_W-1:0]  tsw_d [SETS][WAYS];
    rsp_t             rsp_q;
    rsp_t             rsp_d;

    // ---------------------------------------------------------------
    // Address split
    // ---------------------------------------------------------------
    logic [IDX_W-1:0] rec_idx;
    logic [TAG_W-1:0] rec_tag;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [TS_W-1:0]  rec_part;

    assign rec_idx  = rec_addr[IDX_W-1:0];
    assign rec_tag  = rec_addr[ADDR_W-1:IDX_W];
    assign lk_idx   = lk_addr[IDX_W-1:0];
    assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
    assign rec_part = cur_ic[TS_W-1:0];

    // ---------------------------------------------------------------
    // Row extraction for the two ports
    // ---------------------------------------------------------------
    logic [WAYS-1:0]       rec_row_vld;
    logic [WAYS*TAG_W-1:0] rec_row_tag;
    logic [WAYS*WAY_W-1:0] rec_row_age;
    logic [WAYS-1:0]       lk_row_vld;
    logic [WAYS*TAG_W-1:0] lk_row_tag;
    logic [WAYS*WAY_W-1:0] lk_row_age;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rec_row_vld[w]                 = vld_q[rec_idx][w];
            rec_row_tag[w*TAG_W +: TAG_W]  = tag_q[rec_idx][w];
            rec_row_age[w*WAY_W +: WAY_W]  = age_q[rec_idx][w];
            lk_row_vld[w]                  = vld_q[lk_idx][w];
            lk_row_tag[w*TAG_W +: TAG_W]   = tag_q[lk_idx][w];
            lk_row_age[w*WAY_W +: WAY_W]   = age_q[lk_idx][w];
        end
    end

    // ---------------------------------------------------------------
    // Way search and victim choice, one pair per port
    // ---------------------------------------------------------------
    logic             rec_hit;
    logic [WAY_W-1:0] rec_hit_way;
    logic [WAY_W-1:0] rec_vict;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_hit_way;
    logic [WAY_W-1:0] lk_vict;

    tsm_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rec_match (
        .row_vld (rec_row_vld),
        .row_tag (rec_row_tag),
        .key     (rec_tag),
        .hit     (rec_hit),
        .hit_way (rec_hit_way)
    );

    tsm_lru_victim #(.WAYS(WAYS)) u_rec_victim (
        .row_vld (rec_row_vld),
        .row_age (rec_row_age),
        .victim  (rec_vict)
    );

    tsm_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .row_vld (lk_row_vld),
        .row_tag (lk_row_tag),
        .key     (lk_tag),
        .hit     (lk_hit),
        .hit_way (lk_hit_way)
    );

    tsm_lru_victim #(.WAYS(WAYS)) u_lk_victim (
        .row_vld (lk_row_vld),
        .row_age (lk_row_age),
        .victim  (lk_vict)
    );

    // ---------------------------------------------------------------
    // Lookup stamp selection and rebuild
    // ---------------------------------------------------------------
    logic [WAY_W-1:0] lk_way;
    logic [TS_W-1:0]  lk_part;
    logic [IC_W-1:0]  lk_full;

    always_comb begin
        lk_way = lk_hit ? lk_hit_way : lk_vict;
        // Exclusive requests conflict with any access; shared ones only with
        // stores, which the split form keeps apart.
        if (lk_excl || !SPLIT_RW) begin
            lk_part = tsa_q[lk_idx][lk_way];
        end else begin
            lk_part = tsw_q[lk_idx][lk_way];
        end
    end

    tsm_ts_rebuild #(.IC_W(IC_W), .TS_W(TS_W)) u_rebuild (
        .ic   (cur_ic),
        .part (lk_part),
        .full (lk_full)
    );

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    logic [WAY_W-1:0] rec_way;
    logic [WAY_W-1:0] rec_old_age;

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        age_d = age_q;
        tsa_d = tsa_q;
        tsw_d = tsw_q;

        rec_way     = rec_hit ? rec_hit_way : rec_vict;
        rec_old_age = age_q[rec_idx][rec_way];

        if (rec_valid) begin
            // Move the touched way to the front of the recency order.
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[rec_idx][w] < rec_old_age) begin
                    age_d[rec_idx][w] = age_q[rec_idx][w] + WAY_W'(1);
                end
            end
            age_d[rec_idx][rec_way] = '0;
            vld_d[rec_idx][rec_way] = 1'b1;
            tag_d[rec_idx][rec_way] = rec_tag;
            tsa_d[rec_idx][rec_way] = rec_part;
            // A fresh entry takes the new stamp in both fields (conservative).
            if (SPLIT_RW && (rec_store || !rec_hit)) begin
                tsw_d[rec_idx][rec_way] = rec_part;
            end
        end

        rsp_d.valid = lk_valid;
        rsp_d.hit   = lk_valid && lk_hit;
        rsp_d.ts    = '0;
        if (lk_valid) begin
            if (!lk_hit && (miss_policy_e'(miss_mode) == MISS_CURRENT_IC)) begin
                rsp_d.ts = cur_ic;
            end else begin
                rsp_d.ts = lk_full;
            end
        end
    end

    // ---------------------------------------------------------------
    // State registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w] <= 1'b0;
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= WAY_W'(w);
                    tsa_q[s][w] <= '0;
                    tsw_q[s][w] <= '0;
                end
            end
            rsp_q <= '0;
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
            age_q <= age_d;
            tsa_q <= tsa_d;
            tsw_q <= tsw_d;
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_ts    = rsp_q.ts;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    logic              chk_rec_q;
    logic [ADDR_W-1:0] chk_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_rec_q  <= 1'b0;
            chk_addr_q <= '0;
        end else begin
            chk_rec_q  <= rec_valid;
            chk_addr_q <= rec_addr;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R2

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_ts == '0)); // R2

    AST_CURIC_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && miss_mode) |=> (rsp_ts == $past(cur_ic))); // R6

    AST_RECORDED_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_rec_q && lk_valid && lk_addr == chk_addr_q) |=> rsp_hit); // R3

endmodule

// File: tb/tsm_stamp_store_tb_top.sv
`timescale 1ns/1ps
module tsm_stamp_store_tb_top;

    localparam int S  = 4;
    localparam int W  = 4;
    localparam int AW = 6;
    localparam int IW = 12;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] cur_ic = '0;
    logic          rec_valid = 1'b0;
    logic [AW-1:0] rec_addr = '0;
    logic          rec_store = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_excl = 1'b0;
    logic          miss_mode = 1'b0;

    logic          rv_s, rh_s, rv_u, rh_u;
    logic [IW-1:0] rt_s, rt_u;

    always #4 clk = ~clk;

    tsm_stamp_store #(.SETS(S), .WAYS(W), .ADDR_W(AW), .IC_W(IW), .TS_W(TW), .SPLIT_RW(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_ic(cur_ic),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_store(rec_store),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_excl(lk_excl), .miss_mode(miss_mode),
        .rsp_valid(rv_s), .rsp_hit(rh_s), .rsp_ts(rt_s)
    );

    tsm_stamp_store #(.SETS(S), .WAYS(W), .ADDR_W(AW), .IC_W(IW), .TS_W(TW), .SPLIT_RW(1'b0)) dut_u (
        .clk(clk), .rst_n(rst_n), .cur_ic(cur_ic),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_store(rec_store),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_excl(lk_excl), .miss_mode(miss_mode),
        .rsp_valid(rv_u), .rsp_hit(rh_u), .rsp_ts(rt_u)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model, index 0 = split stamps, 1 = unified; recency by sequence number.
    logic          m_vld [2][S][W];
    logic [3:0]    m_tag [2][S][W];
    logic [TW-1:0] m_any [2][S][W];
    logic [TW-1:0] m_wr  [2][S][W];
    int            m_use [2][S][W];
    int            seqno = 0;

    function automatic logic [IW-1:0] rebuild(input logic [IW-1:0] ic, input logic [TW-1:0] p);
        logic [IW-1:0] c;
        c = (ic & 12'hF00) | {4'h0, p};
        if (c > ic) c = c - 12'h100;
        return c;
    endfunction

    function automatic logic [AW-1:0] mk(input int tg, input int ix);
        return AW'((tg << 2) | ix);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_lookup(input int m, input logic [AW-1:0] a, input bit x, input bit mode,
                                input logic [IW-1:0] ic, output bit hit, output logic [IW-1:0] ts);
        int s;
        int h;
        int old;
        bit full;
        bit use_any;
        logic [TW-1:0] p;
        s = int'(a[1:0]);
        h = -1;
        for (int w = 0; w < W; w++)
            if (m_vld[m][s][w] && m_tag[m][s][w] == a[5:2]) h = w;
        use_any = x || (m == 1);
        hit = (h >= 0);
        if (hit) begin
            p = use_any ? m_any[m][s][h] : m_wr[m][s][h];
            ts = rebuild(ic, p);
        end else if (mode) begin
            ts = ic;
        end else begin
            full = 1'b1;
            old = 0;
            for (int w = 0; w < W; w++) begin
                if (!m_vld[m][s][w]) full = 1'b0;
                else if (m_use[m][s][w] < m_use[m][s][old]) old = w;
            end
            if (!full) p = '0;
            else p = use_any ? m_any[m][s][old] : m_wr[m][s][old];
            ts = rebuild(ic, p);
        end
    endtask

    task automatic model_record(input int m, input logic [AW-1:0] a, input bit st, input logic [IW-1:0] ic);
        int s;
        int h;
        int slot;
        s = int'(a[1:0]);
        h = -1;
        for (int w = 0; w < W; w++)
            if (m_vld[m][s][w] && m_tag[m][s][w] == a[5:2]) h = w;
        if (h >= 0) begin
            slot = h;
        end else begin
            slot = -1;
            for (int w = W - 1; w >= 0; w--) if (!m_vld[m][s][w]) slot = w;
            if (slot < 0) begin
                slot = 0;
                for (int w = 1; w < W; w++) if (m_use[m][s][w] < m_use[m][s][slot]) slot = w;
            end
        end
        m_vld[m][s][slot] = 1'b1;
        m_tag[m][s][slot] = a[5:2];
        m_any[m][s][slot] = ic[TW-1:0];
        m_use[m][s][slot] = seqno;
        if (m == 0 && (st || h < 0)) m_wr[m][s][slot] = ic[TW-1:0];
    endtask

    task automatic step(input string req, input bit rv, input logic [AW-1:0] ra, input bit rs,
                        input bit lv, input logic [AW-1:0] la, input bit lx, input bit mm,
                        input logic [IW-1:0] ic);
        bit eh0, eh1;
        logic [IW-1:0] et0, et1;
        rec_valid = rv; rec_addr = ra; rec_store = rs;
        lk_valid = lv; lk_addr = la; lk_excl = lx; miss_mode = mm; cur_ic = ic;
        eh0 = 1'b0; eh1 = 1'b0; et0 = '0; et1 = '0;
        if (lv) begin
            model_lookup(0, la, lx, mm, ic, eh0, et0);
            model_lookup(1, la, lx, mm, ic, eh1, et1);
        end
        if (rv) begin
            seqno++;
            model_record(0, ra, rs, ic);
            model_record(1, ra, rs, ic);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2", "split valid", 32'(rv_s), 32'(lv));
        chk("R2", "unified valid", 32'(rv_u), 32'(lv));
        if (lv) begin
            chk(req, "split hit", 32'(rh_s), 32'(eh0));
            chk(req, "split ts", 32'(rt_s), 32'(et0));
            chk(req, "unified hit", 32'(rh_u), 32'(eh1));
            chk(req, "unified ts", 32'(rt_u), 32'(et1));
        end else begin
            chk("R2", "idle hit/ts", 32'({rh_s, rt_s, rh_u, rt_u}), 32'(0));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [IW-1:0] ic;
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < S; s++)
                for (int w = 0; w < W; w++) begin
                    m_vld[m][s][w] = 1'b0; m_tag[m][s][w] = '0;
                    m_any[m][s][w] = '0; m_wr[m][s][w] = '0; m_use[m][s][w] = 0;
                end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the outputs
        chk("R1", "reset outputs", 32'({rv_s, rh_s, rt_s, rv_u, rh_u}), 32'(0));
        chk("R1", "reset ts unified", 32'(rt_u), 32'(0));
        // R1: empty store answers a miss
        step("R1", 0, '0, 0, 1, mk(1, 0), 1, 0, 12'h100);

        // R3/R4: fill set 0, look up the first line
        step("R4", 1, mk(1, 0), 0, 0, '0, 0, 0, 12'h105);
        step("R3", 0, '0, 0, 1, mk(1, 0), 1, 0, 12'h106);
        step("R4", 1, mk(2, 0), 1, 0, '0, 0, 0, 12'h110);
        step("R4", 1, mk(3, 0), 0, 0, '0, 0, 0, 12'h120);
        step("R4", 1, mk(4, 0), 0, 0, '0, 0, 0, 12'h130);
        // R5: full set, miss gives the LRU stamp; R6: current IC
        step("R5", 0, '0, 0, 1, mk(5, 0), 1, 0, 12'h131);
        step("R6", 0, '0, 0, 1, mk(5, 0), 1, 1, 12'h132);
        // R4: refresh then overflow evicts the next-oldest line
        step("R4", 1, mk(1, 0), 0, 0, '0, 0, 0, 12'h140);
        step("R4", 1, mk(5, 0), 0, 0, '0, 0, 0, 12'h150);
        step("R4", 0, '0, 0, 1, mk(2, 0), 1, 0, 12'h151);
        step("R4", 0, '0, 0, 1, mk(1, 0), 1, 0, 12'h152);
        // R8: store then load in set 1, both lookup kinds
        step("R8", 1, mk(6, 1), 1, 0, '0, 0, 0, 12'h160);
        step("R8", 1, mk(6, 1), 0, 0, '0, 0, 0, 12'h170);
        step("R8", 0, '0, 0, 1, mk(6, 1), 1, 0, 12'h171);
        step("R8", 0, '0, 0, 1, mk(6, 1), 0, 0, 12'h172);
        step("R8", 1, mk(7, 1), 0, 0, '0, 0, 0, 12'h180);
        step("R8", 0, '0, 0, 1, mk(7, 1), 0, 0, 12'h181);
        // R9: same-cycle record and lookup sees the old contents
        step("R9", 1, mk(8, 2), 0, 1, mk(8, 2), 1, 0, 12'h190);
        step("R9", 0, '0, 0, 1, mk(8, 2), 1, 0, 12'h191);
        // R7: borrow from the upper bits, and the exact boundary
        step("R7", 1, mk(9, 3), 1, 0, '0, 0, 0, 12'h1F0);
        step("R7", 0, '0, 0, 1, mk(9, 3), 1, 0, 12'h205);
        step("R7", 0, '0, 0, 1, mk(9, 3), 0, 0, 12'h2F0);
        // R5: partly filled set, miss uses a zero part
        step("R5", 0, '0, 0, 1, mk(10, 3), 1, 0, 12'h300);

        // R3: long pseudo-random mix
        ic = 12'h300;
        r = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            r = r * 32'd1103515245 + 32'd12345;
            ic = ic + IW'(1 + r[26:24]);
            step("R3", r[16], r[13:8], r[17], r[18] | r[19], r[5:0], r[20], r[21] & r[22], ic);
        end

        // R5: sweep every address in both kinds, LRU miss policy
        for (int a = 0; a < 64; a++) begin
            ic = ic + 12'd3;
            step("R5", 0, '0, 0, 1, AW'(a), 1, 0, ic);
            step("R8", 0, '0, 0, 1, AW'(a), 0, 0, ic);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule